// File: doc/BRIEF.md
# Address Decoder with Remap and Abort

This block sits between a processor's 32-bit address bus and the targets behind it. It classifies every valid access into one of three regions: internal memory at the bottom 4 MB, internal peripherals at the top 4 MB, and the external bus everything in between. For the external bus it produces a one-hot chip-select for the matching bank. For peripherals it aligns narrow accesses to a word and reports which 16 KB peripheral window is addressed. It also flags an abort when an external access hits no usable bank.

A two-state machine controls what is visible at address zero. After reset the machine is in `MAP_BOOT`. Here the lowest 1 MB of the address space is redirected to the boot device on chip-select 0, and only bank 0 of the external bus may be reached. A configuration write that sets the remap command bit takes the transition `remap_cmd` to `MAP_REMAP`. In that state internal SRAM appears at address zero, which makes the exception vectors writable, and all external banks become reachable. `MAP_REMAP` has no exit except reset, so a system maps address zero once, early in boot, and never returns to the boot mapping by software.

All decode outputs are combinational from the access inputs and the current state. The state changes on the clock edge that samples the configuration write.

Top module: `addr_remap_decoder`

## Requirements
- R1: After reset the state is `MAP_BOOT`. A valid access to an address below 1 MB selects the external region and chip-select 0, and the output address is 0x0040_0000 plus the low 20 address bits.
- R2: For a valid access, exactly one region select is high. The effective address is the input address, or the redirected address for a boot-mapped access. Internal memory is effective addresses below 0x0040_0000. Peripherals are effective addresses at or above 0xFFC0_0000. The external bus is everything between.
- R3: A configuration write with bit 0 of the write data at 1 moves the state to `MAP_REMAP` at the next clock edge. From then on, address 0 selects internal memory with output address 0.
- R4: A configuration write with bit 0 at 0 leaves the mapping unchanged, whatever the other data bits hold.
- R5: `MAP_REMAP` is left only by reset. Later configuration writes of any value keep the remapped mapping, and a reset restores the boot mapping.
- R6: In `MAP_BOOT`, internal-region addresses from 1 MB up to 4 MB still select internal memory, and the address passes unchanged.
- R7: External bank k covers 0x0040_0000 + k·1 MB, for 1 MB, with k from 0 to 7. A hit drives chip-select bit k alone, and the address passes unchanged.
- R8: In `MAP_BOOT`, an access that hits banks 1 to 7 drives no chip-select and raises abort. Bank 0 stays reachable.
- R9: An external-region access that matches no enabled bank raises abort and drives no chip-select. With the default table, this covers 0x00C0_0000 and above, up to the peripheral region.
- R10: Abort is never raised for an internal-memory or peripheral access.
- R11: The access size is encoded as 0 for byte, 1 for half-word, 2 for word, and 3 is treated as a narrow access. A peripheral access that is not a word has output address bits [1:0] forced to 0. The peripheral window index is effective address bits [21:14].
- R12: While `acc_valid` is low, all region selects, chip-selects, the window index and abort are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, returns to `MAP_BOOT` |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 32 | Processor address |
| acc_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| cfg_wr | input | 1 | Remap control register write strobe |
| cfg_wdata | input | 32 | Write data; bit 0 is the remap command |
| sel_mem | output | 1 | Internal memory selected |
| sel_ext | output | 1 | External bus selected |
| sel_per | output | 1 | Internal peripherals selected |
| cs_sel | output | NUM_BANKS | One-hot external chip-select |
| out_addr | output | 32 | Redirected and aligned address |
| per_slot | output | 8 | Peripheral 16 KB window index |
| abort | output | 1 | Undefined or blocked external access |

## Verification
Several properties are checked on every cycle while reset is released:
- the region selects are one-hot for a valid access;
- nothing is driven while the access strobe is low;
- abort appears only with the external select, and always exactly one of abort and a chip-select accompanies it;
- chip-selects above bank 0 never appear before remap;
- narrow peripheral accesses leave aligned addresses;
- `MAP_REMAP` is never left without reset.

Only the directed scenarios can show the actual values:
- the redirected boot address and the chosen bank for each address;
- that a zero command bit leaves the boot mapping in place;
- that a reset really brings the boot device back to address zero.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

    // Region boundaries of the 32-bit space
    localparam logic [31:0] INT_TOP   = 32'h0040_0000;
    localparam logic [31:0] PER_BASE  = 32'hFFC0_0000;
    localparam int          PER_SPAN_AW = 22;   // 4 MB peripheral region
    localparam int          PER_WIN_AW  = 14;   // 16 KB per peripheral
    localparam int          SLOT_W      = PER_SPAN_AW - PER_WIN_AW;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic {
        MAP_BOOT  = 1'b0,
        MAP_REMAP = 1'b1
    } map_state_e;

endpackage

// File: rtl/remap_fsm.sv
module remap_fsm
    import addr_dec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic cmd_bit,
    output logic remapped
);

    map_state_e state_q;
    map_state_e state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MAP_BOOT:  if (cmd_wr && cmd_bit) state_d = MAP_REMAP; // remap_cmd
            MAP_REMAP: state_d = MAP_REMAP;                        // only reset exits
            default:   state_d = MAP_BOOT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MAP_BOOT;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        remapped = (state_q == MAP_REMAP);
    end

    assert_remap_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MAP_REMAP) |=> (state_q == MAP_REMAP));

    assert_zero_cmd_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MAP_BOOT && cmd_wr && !cmd_bit) |=> (state_q == MAP_BOOT));

    assert_cmd_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_bit) |=> remapped);

endmodule

// File: rtl/ext_bank_match.sv
module ext_bank_match #(
    parameter int                    NUM_BANKS = 8,
    parameter int                    BANK_AW   = 20,
    parameter logic [NUM_BANKS-1:0]  BANK_EN   = '1,
    parameter logic [31:0]           EXT_LO    = 32'h0040_0000
) (
    input  logic [31:0]          addr,
    output logic [NUM_BANKS-1:0] hit
);

    localparam int TAG_W = 32 - BANK_AW;

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        localparam logic [31:0] BASE = EXT_LO + (32'(k) << BANK_AW);
        if (BANK_EN[k]) begin : g_on
            assign hit[k] = (addr[31:BANK_AW] == BASE[31:BANK_AW]);
        end else begin : g_off
            assign hit[k] = 1'b0;
        end
    end

    logic [TAG_W-1:0] unused_tag;
    assign unused_tag = '0;

    always_comb begin
        assert_bank_onehot_R7: assert ($onehot0(hit));
    end

endmodule

// File: rtl/addr_remap_decoder.sv
module addr_remap_decoder
    import addr_dec_pkg::*;
#(
    parameter int                   NUM_BANKS = 8,
    parameter int                   BANK_AW   = 20,
    parameter logic [NUM_BANKS-1:0] BANK_EN   = '1,
    parameter int                   BOOT_AW   = 20,
    parameter int                   REMAP_BIT = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_valid,
    input  logic [31:0]          acc_addr,
    input  logic [1:0]           acc_size,
    input  logic                 cfg_wr,
    input  logic [31:0]          cfg_wdata,
    output logic                 sel_mem,
    output logic                 sel_ext,
    output logic                 sel_per,
    output logic [NUM_BANKS-1:0] cs_sel,
    output logic [31:0]          out_addr,
    output logic [SLOT_W-1:0]    per_slot,
    output logic                 abort
);

    localparam logic [31:0]          EXT_LO    = INT_TOP;
    localparam logic [NUM_BANKS-1:0] BOOT_MASK = NUM_BANKS'(1);

    logic                 remapped;
    logic                 boot_alias;
    logic [31:0]          eff_addr;
    logic [NUM_BANKS-1:0] bank_hit;
    logic [NUM_BANKS-1:0] bank_ok;

    remap_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cfg_wr),
        .cmd_bit  (cfg_wdata[REMAP_BIT]),
        .remapped (remapped)
    );

    // boot device redirect of the low window while not remapped
    always_comb begin
        boot_alias = !remapped && (acc_addr[31:BOOT_AW] == '0);
        eff_addr   = boot_alias ? (EXT_LO | 32'(acc_addr[BOOT_AW-1:0])) : acc_addr;
    end

    ext_bank_match #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_AW   (BANK_AW),
        .BANK_EN   (BANK_EN),
        .EXT_LO    (EXT_LO)
    ) u_match (
        .addr (eff_addr),
        .hit  (bank_hit)
    );

    assign bank_ok = bank_hit & (remapped ? {NUM_BANKS{1'b1}} : BOOT_MASK);

    // output decode
    always_comb begin
        sel_mem  = 1'b0;
        sel_ext  = 1'b0;
        sel_per  = 1'b0;
        cs_sel   = '0;
        abort    = 1'b0;
        per_slot = '0;
        out_addr = eff_addr;
        if (acc_valid) begin
            if (eff_addr < INT_TOP) begin
                sel_mem = 1'b1;
            end else if (eff_addr >= PER_BASE) begin
                sel_per  = 1'b1;
                per_slot = eff_addr[PER_SPAN_AW-1:PER_WIN_AW];
                if (acc_size_e'(acc_size) != SZ_WORD) out_addr[1:0] = 2'b00;
            end else begin
                sel_ext = 1'b1;
                cs_sel  = bank_ok;
                abort   = (bank_ok == '0);
            end
        end
    end

    assert_region_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> $onehot({sel_mem, sel_ext, sel_per}));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (!abort && cs_sel == '0 && !sel_mem && !sel_ext && !sel_per));

    assert_abort_ext_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> sel_ext);

    assert_cs_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_sel[NUM_BANKS-1:1] != '0) |-> remapped);

    assert_cs_xor_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ext |-> ($onehot(cs_sel) != abort));

    assert_per_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_per && acc_size != 2'd2) |-> (out_addr[1:0] == 2'b00));

    assert_boot_cs0_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !remapped && acc_addr[31:BOOT_AW] == '0) |-> cs_sel[0]);

endmodule

// File: tb/test_addr_remap_decoder.sv
module test_addr_remap_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_size = 2'd2;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        sel_mem, sel_ext, sel_per, abort;
    logic [7:0]  cs_sel;
    logic [31:0] out_addr;
    logic [7:0]  per_slot;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    addr_remap_decoder i_addr_remap_decoder (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_size(acc_size), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .sel_mem(sel_mem), .sel_ext(sel_ext), .sel_per(sel_per), .cs_sel(cs_sel),
        .out_addr(out_addr), .per_slot(per_slot), .abort(abort)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // sel = {mem, ext, per}
    task automatic probe(input string req, input logic [31:0] a, input logic [1:0] sz,
                         input logic [2:0] sel, input logic [7:0] cs,
                         input logic [31:0] oa, input logic [7:0] slot, input logic ab);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_size = sz;
        #2;
        chk(req, "sel", {sel_mem, sel_ext, sel_per}, sel);
        chk(req, "cs", cs_sel, cs);
        chk(req, "addr", out_addr, oa);
        chk(req, "slot", per_slot, slot);
        chk(req, "abort", abort, ab);
        acc_valid = 1'b0;
    endtask

    task automatic cfg_write(input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        acc_valid = 1'b0; acc_addr = 32'h0040_0000;
        #2;
        chk("R12", "idle outputs", {sel_mem, sel_ext, sel_per, abort, cs_sel, per_slot}, '0);
        probe("R1", 32'h0000_0010, 2'd2, 3'b010, 8'h01, 32'h0040_0010, 8'h00, 1'b0);
        probe("R6", 32'h0010_0020, 2'd2, 3'b100, 8'h00, 32'h0010_0020, 8'h00, 1'b0);
        probe("R8", 32'h0050_0000, 2'd2, 3'b010, 8'h00, 32'h0050_0000, 8'h00, 1'b1);
        probe("R8", 32'h0040_0004, 2'd2, 3'b010, 8'h01, 32'h0040_0004, 8'h00, 1'b0);
    endtask

    task automatic t_zero_write();
        cfg_write(32'hFFFF_FFFE);
        probe("R4", 32'h0000_0000, 2'd2, 3'b010, 8'h01, 32'h0040_0000, 8'h00, 1'b0);
        probe("R4", 32'h00A0_0000, 2'd2, 3'b010, 8'h00, 32'h00A0_0000, 8'h00, 1'b1);
    endtask

    task automatic t_remap();
        cfg_write(32'h0000_0001);
        probe("R3", 32'h0000_0000, 2'd2, 3'b100, 8'h00, 32'h0000_0000, 8'h00, 1'b0);
        probe("R3", 32'h0000_0020, 2'd0, 3'b100, 8'h00, 32'h0000_0020, 8'h00, 1'b0);
        for (int k = 0; k < 8; k++) begin
            logic [31:0] a;
            a = 32'h0040_0000 + (32'(k) << 20) + 32'h123;
            probe("R7", a, 2'd2, 3'b010, 8'(1 << k), a, 8'h00, 1'b0);
        end
        probe("R9", 32'h00C0_0000, 2'd2, 3'b010, 8'h00, 32'h00C0_0000, 8'h00, 1'b1);
        probe("R9", 32'h8000_0000, 2'd2, 3'b010, 8'h00, 32'h8000_0000, 8'h00, 1'b1);
        probe("R2", 32'hFFBF_FFFC, 2'd2, 3'b010, 8'h00, 32'hFFBF_FFFC, 8'h00, 1'b1);
    endtask

    task automatic t_sticky();
        cfg_write(32'h0000_0000);
        cfg_write(32'h0000_0001);
        probe("R5", 32'h0000_0000, 2'd2, 3'b100, 8'h00, 32'h0000_0000, 8'h00, 1'b0);
    endtask

    task automatic t_periph();
        probe("R11", 32'hFFFF_F003, 2'd0, 3'b001, 8'h00, 32'hFFFF_F000, 8'hFF, 1'b0);
        probe("R11", 32'hFFC0_4002, 2'd1, 3'b001, 8'h00, 32'hFFC0_4000, 8'h01, 1'b0);
        probe("R11", 32'hFFC0_8000, 2'd2, 3'b001, 8'h00, 32'hFFC0_8000, 8'h02, 1'b0);
        probe("R10", 32'hFFC0_0001, 2'd3, 3'b001, 8'h00, 32'hFFC0_0000, 8'h00, 1'b0);
        probe("R10", 32'h003F_FFFC, 2'd2, 3'b100, 8'h00, 32'h003F_FFFC, 8'h00, 1'b0);
    endtask

    task automatic t_reset_again();
        do_reset();
        probe("R5", 32'h0000_0008, 2'd2, 3'b010, 8'h01, 32'h0040_0008, 8'h00, 1'b0);
        probe("R5", 32'h0060_0000, 2'd2, 3'b010, 8'h00, 32'h0060_0000, 8'h00, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_zero_write();
        t_remap();
        t_sticky();
        t_periph();
        t_reset_again();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule